// File: doc/BRIEF.md
# Prefixed Bit-Manipulation and Shift Unit

This unit executes the second page of a small 8-bit CPU's instruction set, the one reached after a prefix byte. The sequencer hands it the second opcode byte, the 8-bit operand it has already fetched, and the current flag nibble. One clock later the unit returns the result byte and a write-back enable. It also returns the new flags, the cycle cost of the instruction, the operand slot the opcode names, and whether that slot is the memory operand.

The opcode byte is decoded from its bit fields, not from a table. Bits 7:6 pick the family: shift/rotate, test, clear or set. Bits 5:3 pick either the shift kind or the bit index. Bits 2:0 pick the operand slot. The unit does not fetch, read the register file or touch memory. It only reports which slot the instruction uses, so that the sequencer can route the data and account for the longer memory timing.

Top module: `cbx_unit`

## Requirements
- R1: While rst_n is low at a clock edge, and after that edge, out_valid, wr_en, result, flags_out, cycles, mem_opnd and src_sel are all zero.
- R2: All outputs update at the first rising edge after a cycle with in_valid high, and out_valid is high exactly in the cycle after in_valid was high. When in_valid is low, result, flags_out, cycles, mem_opnd and src_sel keep their values, and out_valid and wr_en are low.
- R3: src_sel equals opcode bits 2:0. The slot order is 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=(HL), 7=A. mem_opnd is high only for slot 6.
- R4: cycles is 8 for a register slot and 16 for the memory slot.
- R5: Opcodes 0x00-0x07 rotate left circularly, and 0x08-0x0F rotate right circularly. The carry takes the bit that leaves the byte.
- R6: Opcodes 0x10-0x17 rotate left through carry, and 0x18-0x1F rotate right through carry. The incoming C enters the vacated bit, and the outgoing bit becomes C.
- R7: Opcodes 0x20-0x27 shift left and insert 0. Opcodes 0x28-0x2F shift right arithmetically and keep bit 7. Opcodes 0x38-0x3F shift right logically and insert 0. The carry takes the bit that leaves the byte.
- R8: Opcodes 0x30-0x37 swap the two nibbles. Z is set when the result is zero, and N, H and C are cleared.
- R9: Flags use the layout bit3=Z, bit2=N, bit1=H, bit0=C. Every opcode in 0x00-0x3F sets Z exactly when the result is zero and clears N and H.
- R10: Opcodes 0x40-0x7F test bit n (n = opcode bits 5:3). They set Z when that bit is 0, clear N, set H and keep C. wr_en stays low, and result equals the operand.
- R11: Opcodes 0x80-0xBF clear bit n and opcodes 0xC0-0xFF set bit n. No other bit changes, and flags_out equals flags_in.
- R12: wr_en is high in the output cycle of every accepted opcode outside 0x40-0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Opcode, operand and flags are presented this cycle |
| op_byte | input | 8 | Second opcode byte |
| operand | input | 8 | Operand value fetched by the sequencer |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| out_valid | output | 1 | Outputs hold the result of the last accepted opcode |
| wr_en | output | 1 | Result must be written back to the operand slot |
| result | output | 8 | Result byte |
| flags_out | output | 4 | Updated flags {Z,N,H,C} |
| cycles | output | 5 | Instruction cost in clock cycles (8 or 16) |
| mem_opnd | output | 1 | Operand slot is the memory operand |
| src_sel | output | 3 | Operand slot index |

## Verification
On every cycle the assertions check the one-cycle valid latency and the write-back rule: no write for the test family, and a write for every other family. They also check how the cycle cost pairs with the memory slot, that flags pass through unchanged for clear and set, and the fixed N, H and C behaviour of the test and shift families. Only the bench scenarios can show the actual data transformations: rotate direction, the carry entering through RL and RR, sign retention in SRA, the nibble swap, and which bit an index selects. The bench's directed steps also show that outputs hold while idle and that reset clears them mid-run.

// File: rtl/cbx_pkg.sv
`timescale 1ns/1ps
// Shared types for the prefixed bit unit: family code from opcode bits 7:6,
// shift kind from bits 5:3, and the flag nibble layout.
package cbx_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        FAM_SHIFT = 2'd0,
        FAM_TEST  = 2'd1,
        FAM_CLEAR = 2'd2,
        FAM_SET   = 2'd3
    } fam_e;

    typedef enum logic [2:0] {
        SK_ROLC = 3'd0,
        SK_RORC = 3'd1,
        SK_ROLT = 3'd2,
        SK_RORT = 3'd3,
        SK_SHLA = 3'd4,
        SK_SHRA = 3'd5,
        SK_NSWP = 3'd6,
        SK_SHRL = 3'd7
    } skind_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;
endpackage

// File: rtl/cbx_decode.sv
`timescale 1ns/1ps
// Splits the second opcode byte into family, sub-field and operand slot.
// Assumes the page is fully regular; every byte value is a legal opcode.
module cbx_decode
    import cbx_pkg::*;
#(
    parameter int MEM_SLOT = 6
) (
    input  logic [7:0] op,
    output fam_e       fam,
    output logic [2:0] sub,
    output logic [2:0] slot,
    output logic       is_mem
);
    // Field extraction straight from the bit layout.
    always_comb begin
        fam    = fam_e'(op[7:6]);
        sub    = op[5:3];
        slot   = op[2:0];
        is_mem = (op[2:0] == 3'(MEM_SLOT));
    end
endmodule

// File: rtl/cbx_shift.sv
`timescale 1ns/1ps
// Rotate, shift and nibble-swap datapath for the first quarter of the page.
// Assumes an 8-bit operand; the flag result follows the shift-family rules.
module cbx_shift
    import cbx_pkg::*;
(
    input  logic [7:0] a,
    input  logic [2:0] kind,
    input  logic       c_in,
    output logic [7:0] r,
    output flags_t     f
);
    logic out_bit;

    // Select the shifted byte and the bit that leaves it.
    always_comb begin
        unique case (skind_e'(kind))
            SK_ROLC: begin r = {a[6:0], a[7]}; out_bit = a[7]; end
            SK_RORC: begin r = {a[0], a[7:1]}; out_bit = a[0]; end
            SK_ROLT: begin r = {a[6:0], c_in}; out_bit = a[7]; end
            SK_RORT: begin r = {c_in, a[7:1]}; out_bit = a[0]; end
            SK_SHLA: begin r = {a[6:0], 1'b0}; out_bit = a[7]; end
            SK_SHRA: begin r = {a[7], a[7:1]}; out_bit = a[0]; end
            SK_NSWP: begin r = {a[3:0], a[7:4]}; out_bit = 1'b0; end
            default: begin r = {1'b0, a[7:1]}; out_bit = a[0]; end
        endcase
    end

    // Flags: zero test on the result, N and H cleared, carry from the lost bit.
    always_comb begin
        f.z = (r == 8'h00);
        f.n = 1'b0;
        f.h = 1'b0;
        f.c = out_bit;
    end
endmodule

// File: rtl/cbx_bitop.sv
`timescale 1ns/1ps
// Single-bit test, clear and set for the upper three quarters of the page.
// Assumes fam is not FAM_SHIFT when its outputs are used.
module cbx_bitop
    import cbx_pkg::*;
#(
    parameter int W = DATA_W,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     a,
    input  logic [IDX_W-1:0] idx,
    input  fam_e             fam,
    input  flags_t           f_in,
    output logic [W-1:0]     r,
    output flags_t           f,
    output logic             wr
);
    logic [W-1:0] mask;

    // One-hot mask of the addressed bit.
    always_comb mask = W'(1) << idx;

    // Result byte, flag update and write decision per family.
    always_comb begin
        r  = a;
        f  = f_in;
        wr = 1'b1;
        unique case (fam)
            FAM_TEST: begin
                f.z = ~|(a & mask);
                f.n = 1'b0;
                f.h = 1'b1;
                wr  = 1'b0;
            end
            FAM_CLEAR: r = a & ~mask;
            FAM_SET:   r = a | mask;
            default:   wr = 1'b0;
        endcase
    end
endmodule

// File: rtl/cbx_unit.sv
`timescale 1ns/1ps
// Top of the prefixed bit unit. Decodes the second opcode byte, runs the
// shift or bit datapath, and registers all outputs one cycle after in_valid.
// Assumes the sequencer already fetched the operand from the slot it names.
module cbx_unit
    import cbx_pkg::*;
#(
    parameter int CYC_REG  = 8,
    parameter int CYC_MEM  = 16,
    parameter int MEM_SLOT = 6,
    localparam int CYC_W   = $clog2(CYC_MEM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       op_byte,
    input  logic [7:0]       operand,
    input  logic [3:0]       flags_in,
    output logic             out_valid,
    output logic             wr_en,
    output logic [7:0]       result,
    output logic [3:0]       flags_out,
    output logic [CYC_W-1:0] cycles,
    output logic             mem_opnd,
    output logic [2:0]       src_sel
);
    fam_e       fam;
    logic [2:0] sub;
    logic [2:0] slot;
    logic       is_mem;
    logic [7:0] sh_r;
    flags_t     sh_f;
    logic [7:0] bo_r;
    flags_t     bo_f;
    logic       bo_wr;
    logic [7:0] nx_r;
    flags_t     nx_f;
    logic       nx_wr;
    flags_t     f_in;

    always_comb f_in = flags_t'(flags_in);

    cbx_decode #(.MEM_SLOT(MEM_SLOT)) u_dec (
        .op     (op_byte),
        .fam    (fam),
        .sub    (sub),
        .slot   (slot),
        .is_mem (is_mem)
    );

    cbx_shift u_shf (
        .a    (operand),
        .kind (sub),
        .c_in (f_in.c),
        .r    (sh_r),
        .f    (sh_f)
    );

    cbx_bitop #(.W(DATA_W)) u_bit (
        .a    (operand),
        .idx  (sub),
        .fam  (fam),
        .f_in (f_in),
        .r    (bo_r),
        .f    (bo_f),
        .wr   (bo_wr)
    );

    // Merge the two datapaths by family.
    always_comb begin
        if (fam == FAM_SHIFT) begin
            nx_r  = sh_r;
            nx_f  = sh_f;
            nx_wr = 1'b1;
        end else begin
            nx_r  = bo_r;
            nx_f  = bo_f;
            nx_wr = bo_wr;
        end
    end

    // Output register: load on in_valid, hold data otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            result    <= '0;
            flags_out <= '0;
            cycles    <= '0;
            mem_opnd  <= 1'b0;
            src_sel   <= '0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid & nx_wr;
            if (in_valid) begin
                result    <= nx_r;
                flags_out <= nx_f;
                cycles    <= is_mem ? CYC_W'(CYC_MEM) : CYC_W'(CYC_REG);
                mem_opnd  <= is_mem;
                src_sel   <= slot;
            end
        end
    end
endmodule

// File: rtl/cbx_unit_chk.sv
`timescale 1ns/1ps
// Property checker for cbx_unit, attached by bind. Relates registered
// outputs to the inputs of the previous cycle.
module cbx_unit_chk #(
    parameter int CYC_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [7:0]       op_byte,
    input logic [3:0]       flags_in,
    input logic             out_valid,
    input logic             wr_en,
    input logic [7:0]       result,
    input logic [3:0]       flags_out,
    input logic [CYC_W-1:0] cycles,
    input logic             mem_opnd
);
    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R1
    idle_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !wr_en);

    // R4
    cost_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mem_opnd ? (cycles == CYC_W'(16)) : (cycles == CYC_W'(8))));

    // R10
    test_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_byte[7:6]) == 2'b01)
        |-> (!wr_en && flags_out[2:1] == 2'b01 && flags_out[0] == $past(flags_in[0])));

    // R11
    bit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_byte[7])) |-> (flags_out == $past(flags_in)));

    // R9
    shift_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_byte[7:6]) == 2'b00)
        |-> (flags_out[2:1] == 2'b00 && flags_out[3] == (result == 8'h00)));

    // R12
    write_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_byte[7:6]) != 2'b01) |-> wr_en);
endmodule

bind cbx_unit cbx_unit_chk #(.CYC_W(CYC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_byte   (op_byte),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .result    (result),
    .flags_out (flags_out),
    .cycles    (cycles),
    .mem_opnd  (mem_opnd)
);

// File: tb/tb_cbx_unit.sv
`timescale 1ns/1ps
module tb_cbx_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] op_byte = 8'h00;
    logic [7:0] operand = 8'h00;
    logic [3:0] flags_in = 4'h0;
    logic       out_valid;
    logic       wr_en;
    logic [7:0] result;
    logic [3:0] flags_out;
    logic [4:0] cycles;
    logic       mem_opnd;
    logic [2:0] src_sel;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cbx_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_byte(op_byte),
        .operand(operand), .flags_in(flags_in), .out_valid(out_valid),
        .wr_en(wr_en), .result(result), .flags_out(flags_out),
        .cycles(cycles), .mem_opnd(mem_opnd), .src_sel(src_sel)
    );

    // Vectors: opcode, operand, flags in {Z,N,H,C}, expected result, flags, write.
    localparam int NV = 16;
    localparam logic [7:0] V_OP [NV] = '{8'h00, 8'h0E, 8'h11, 8'h17, 8'h1A, 8'h23, 8'h2C, 8'h3D,
                                         8'h30, 8'h36, 8'h47, 8'h7E, 8'h98, 8'hBF, 8'hC1, 8'hF6};
    localparam logic [7:0] V_A  [NV] = '{8'h85, 8'h01, 8'h80, 8'h00, 8'h01, 8'hC0, 8'h81, 8'h01,
                                         8'hA5, 8'h00, 8'hFE, 8'h80, 8'hFF, 8'h80, 8'h00, 8'h00};
    localparam logic [3:0] V_FI [NV] = '{4'h0, 4'h0, 4'h0, 4'h1, 4'h1, 4'h0, 4'hE, 4'h0,
                                         4'h1, 4'h7, 4'h1, 4'h0, 4'hA, 4'h5, 4'h0, 4'hF};
    localparam logic [7:0] V_R  [NV] = '{8'h0B, 8'h80, 8'h00, 8'h01, 8'h80, 8'h80, 8'hC0, 8'h00,
                                         8'h5A, 8'h00, 8'hFE, 8'h80, 8'hF7, 8'h00, 8'h01, 8'h40};
    localparam logic [3:0] V_FO [NV] = '{4'h1, 4'h1, 4'h9, 4'h0, 4'h1, 4'h1, 4'h1, 4'h9,
                                         4'h0, 4'h8, 4'hB, 4'h2, 4'hA, 4'h5, 4'h0, 4'hF};
    localparam logic       V_WR [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                         1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [7:0] op);
        if (op[7:6] == 2'b01) return "R10";
        if (op[7]) return "R11";
        if (op[5:3] == 3'd6) return "R8";
        if (op[5:4] == 2'b00) return "R5";
        if (op[5:4] == 2'b01) return "R6";
        return "R7";
    endfunction

    task automatic issue(input logic [7:0] op, input logic [7:0] a, input logic [3:0] f);
        @(negedge clk);
        in_valid = 1'b1;
        op_byte  = op;
        operand  = a;
        flags_in = f;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R2 actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({out_valid, wr_en, result, flags_out, cycles, mem_opnd, src_sel} == '0, "R1 reset",
              16'({out_valid, wr_en, result}), 16'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(V_OP[i], V_A[i], V_FI[i]);
            check(out_valid == 1'b1, "R2 valid", 16'(out_valid), 16'h1);
            check(result == V_R[i], tag_of(V_OP[i]), 16'(result), 16'(V_R[i]));
            check(flags_out == V_FO[i], (V_OP[i][7:6] == 2'b00) ? "R9 flags" : tag_of(V_OP[i]),
                  16'(flags_out), 16'(V_FO[i]));
            check(wr_en == V_WR[i], "R12 write", 16'(wr_en), 16'(V_WR[i]));
            check(src_sel == V_OP[i][2:0] && mem_opnd == (V_OP[i][2:0] == 3'd6), "R3 slot",
                  16'({mem_opnd, src_sel}), 16'({V_OP[i][2:0] == 3'd6, V_OP[i][2:0]}));
            check(cycles == ((V_OP[i][2:0] == 3'd6) ? 5'd16 : 5'd8), "R4 cost",
                  16'(cycles), 16'((V_OP[i][2:0] == 3'd6) ? 16 : 8));
        end

        // R2: idle cycle with new inputs: data holds, valid and write low.
        issue(8'hC7, 8'h00, 4'h0);
        op_byte = 8'h00; operand = 8'hFF; flags_in = 4'hF;
        @(negedge clk);
        check(!out_valid && !wr_en, "R2 idle", 16'({out_valid, wr_en}), 16'h0);
        check(result == 8'h01 && flags_out == 4'h0, "R2 hold", 16'({result, flags_out}), 16'h010);

        // R6: RR with incoming carry clear shifts in 0.
        issue(8'h18, 8'h03, 4'h0);
        check(result == 8'h01 && flags_out == 4'h1, "R6 rr c0", 16'({result, flags_out}), 16'h011);
        // R7: SRA of positive value keeps 0 in bit 7.
        issue(8'h2F, 8'h7E, 4'h1);
        check(result == 8'h3F && flags_out == 4'h0, "R7 sra pos", 16'({result, flags_out}), 16'h3F0);
        // R5: RRC leaves zero result with Z.
        issue(8'h09, 8'h00, 4'h1);
        check(result == 8'h00 && flags_out == 4'h8, "R5 rrc zero", 16'({result, flags_out}), 16'h008);
        // R10: BIT 3 on a set bit keeps carry set, Z clear.
        issue(8'h5D, 8'h08, 4'h9);
        check(flags_out == 4'h3 && !wr_en, "R10 bit set", 16'({wr_en, flags_out}), 16'h003);

        // R1: reset mid-run clears outputs.
        issue(8'hFF, 8'h00, 4'hF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(result == 8'h00 && flags_out == 4'h0 && cycles == 5'd0 && !out_valid, "R1 midrun",
              16'({result, flags_out}), 16'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule